// File: doc/BRIEF.md
# Span Card Control Register Block

This block is the small byte-wide control register file that sits on the local bus of a four-span T1/E1 framer card. Software uses it to select the timing reference, which is free run or lock to one of the four spans. It also sets the framing divisor mode, the serial loopbacks, the master-sync output, the per-span LED pair, two test pins and a framer silicon revision mode.

Reads of the base offset return a status byte. The block also produces the single card interrupt line. An internal pending flag is raised by a one-cycle frame tick and is cleared by writing a one to an action bit of the control register. The external framer interrupt input can be gated onto the same line by its own enable. All of this is qualified by a master interrupt enable.

The serial datapath steering is combinational. Remote loopback sends the received line data back out on the transmit line. Local loopback feeds the block's transmit data straight back into the receive path.

Top module: `card_ctl_regs`

## Requirements
- R1: While reset is low and after it is released, every register is zero. This gives sync_sel 0, all pin outputs 0, irq_out 0, and loopbacks off so that line_tx_out = tx_ser_in and rx_ser_out = line_rx_in.
- R2: A write to offset 0x400 stores the sync source from data bits 2:0. sync_sel shows it from the cycle after the write: 0 is free run, 1 to 4 select span 1 to 4, and 5 to 7 are shown as 0.
- R3: A read (bus_rd high) of offset 0x400 returns, in the same cycle, the interrupt enable in bit 0, the internal pending flag in bit 1 and the framer_irq input level in bit 2, with bits 7:3 zero.
- R4: A write to offset 0x401 sets test1_out from bit 1, master_en from bit 3 and e1_mode from bit 4 (1 = E1), visible the cycle after the write. Bits 0 and 2 are the interrupt enable and framer interrupt enable.
- R5: With control bit 5 (remote loopback) set, line_tx_out equals line_rx_in. Otherwise it equals tx_ser_in.
- R6: With control bit 6 (local loopback) set, rx_ser_out equals tx_ser_in. Otherwise it equals line_rx_in.
- R7: A write to offset 0x402 sets led[7:0] the cycle after. Span n green is bit 2(n-1) and red is bit 2(n-1)+1.
- R8: A write to offset 0x403 sets test2_out from data bit 0 only, and a write to 0x404 sets late_rev_mode from data bit 0 only.
- R9: A frame_tick sets the pending flag on the next edge, and the flag holds until a write to 0x401 with bit 7 set clears it. If a tick and that write occur in the same cycle, the flag stays set. Bit 7 is not stored.
- R10: irq_out is high exactly when the interrupt enable is set and either the pending flag is set or both the framer interrupt enable and framer_irq are high.
- R11: Reads return zero when bus_rd is low or the offset is not 0x400. Writes to offsets other than 0x400 to 0x404 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 11 | Local bus byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read qualifier |
| bus_rdata | output | 8 | Read data, combinational |
| frame_tick | input | 1 | One-cycle internal interrupt source |
| framer_irq | input | 1 | Interrupt from the framer device |
| tx_ser_in | input | 4 | Transmit serial data from buffers, one lane per span |
| line_rx_in | input | 4 | Receive serial data from the framer |
| line_tx_out | output | 4 | Transmit serial data to the framer |
| rx_ser_out | output | 4 | Receive serial data to buffers |
| irq_out | output | 1 | Card interrupt |
| test1_out | output | 1 | Test pin 1 |
| test2_out | output | 1 | Test pin 2 |
| master_en | output | 1 | External sync master enable |
| e1_mode | output | 1 | Divisor mode, 1 = E1 |
| sync_sel | output | 3 | Timing source, 0 free run, 1 to 4 span |
| led | output | 8 | Span LED pairs |
| late_rev_mode | output | 1 | Later framer revision mode |

## Verification
Register-driven pins (R2, R4, R7, R8) and the pending flag (R9) change on the edge that ends the write or tick cycle. The bench therefore drives at a falling edge and samples at the next falling edge. Status reads, irq_out and the loopback paths are combinational. They are sampled one time step after the inputs change, in the same half cycle, with no edge in between. The tick-against-acknowledge case presents both in one cycle and then samples after a single edge.

// File: rtl/card_ctl_regs.sv
module card_ctl_regs #(
  parameter int ADDR_W = 11,
  parameter int LANES = 4,
  parameter logic [ADDR_W-1:0] BASE = 11'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              frame_tick,
  input  logic              framer_irq,
  input  logic [LANES-1:0]  tx_ser_in,
  input  logic [LANES-1:0]  line_rx_in,
  output logic [LANES-1:0]  line_tx_out,
  output logic [LANES-1:0]  rx_ser_out,
  output logic              irq_out,
  output logic              test1_out,
  output logic              test2_out,
  output logic              master_en,
  output logic              e1_mode,
  output logic [2:0]        sync_sel,
  output logic [7:0]        led,
  output logic              late_rev_mode
);
  localparam logic [ADDR_W-1:0] A_SYNC = BASE;
  localparam logic [ADDR_W-1:0] A_CTL  = BASE + 1;
  localparam logic [ADDR_W-1:0] A_LED  = BASE + 2;
  localparam logic [ADDR_W-1:0] A_TST  = BASE + 3;
  localparam logic [ADDR_W-1:0] A_REV  = BASE + 4;

  logic [2:0] sync_q;
  logic [6:0] ctl_q;
  logic [7:0] led_q;
  logic       tst2_q, rev_q, pend_q;

  wire wr_sync = bus_wr && bus_addr == A_SYNC;
  wire wr_ctl  = bus_wr && bus_addr == A_CTL;
  wire ack     = wr_ctl && bus_wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      ctl_q  <= '0;
      led_q  <= '0;
      tst2_q <= 1'b0;
      rev_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_sync) sync_q <= bus_wdata[2:0];
      if (wr_ctl)  ctl_q  <= bus_wdata[6:0];
      if (bus_wr && bus_addr == A_LED) led_q  <= bus_wdata;
      if (bus_wr && bus_addr == A_TST) tst2_q <= bus_wdata[0];
      if (bus_wr && bus_addr == A_REV) rev_q  <= bus_wdata[0];
      if (frame_tick)  pend_q <= 1'b1;
      else if (ack)    pend_q <= 1'b0;
    end
  end

  wire irq_en  = ctl_q[0];
  wire fr_en   = ctl_q[2];
  wire rem_lb  = ctl_q[5];
  wire loc_lb  = ctl_q[6];

  assign sync_sel      = (sync_q > 3'd4) ? 3'd0 : sync_q;
  assign test1_out     = ctl_q[1];
  assign master_en     = ctl_q[3];
  assign e1_mode       = ctl_q[4];
  assign led           = led_q;
  assign test2_out     = tst2_q;
  assign late_rev_mode = rev_q;

  assign irq_out = irq_en && (pend_q || (fr_en && framer_irq));

  assign bus_rdata = (bus_rd && bus_addr == A_SYNC)
                   ? {5'b0, framer_irq, pend_q, irq_en} : 8'h00;

  assign line_tx_out = rem_lb ? line_rx_in : tx_ser_in;
  assign rx_ser_out  = loc_lb ? tx_ser_in  : line_rx_in;
endmodule

module card_ctl_regs_chk #(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] BASE = 11'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              frame_tick,
  input logic              pend_q,
  input logic [2:0]        sync_sel
);
  wire ack_wr = bus_wr && bus_addr == BASE + 1 && bus_wdata[7];

  a_r9_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> pend_q);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !frame_tick) |=> !pend_q);
  a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_wr && !frame_tick) |=> $stable(pend_q));
  a_r2_sync_range: assert property (@(posedge clk) disable iff (!rst_n)
    sync_sel <= 3'd4);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:3] == 5'b0);
endmodule

bind card_ctl_regs card_ctl_regs_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .frame_tick(frame_tick), .pend_q(pend_q), .sync_sel(sync_sel));

// File: tb/sim_card_ctl_regs.sv
module sim_card_ctl_regs;
  logic clk = 0, rst_n = 0;
  logic [10:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, led;
  logic bus_wr = 0, bus_rd = 0, frame_tick = 0, framer_irq = 0;
  logic [3:0] tx_ser_in = '0, line_rx_in = '0, line_tx_out, rx_ser_out;
  logic irq_out, test1_out, test2_out, master_en, e1_mode, late_rev_mode;
  logic [2:0] sync_sel;
  int vectors = 0, misses = 0;

  always #4 clk = ~clk;

  card_ctl_regs u0 (.*);

  // {addr, data, sync, test1, master, e1, test2, rev, led}
  localparam logic [34:0] VEC [11] = '{
    {11'h400, 8'h03, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {11'h400, 8'h06, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {11'h400, 8'h04, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {11'h401, 8'h1A, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {11'h402, 8'hC3, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3},
    {11'h403, 8'hFE, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3},
    {11'h403, 8'h01, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hC3},
    {11'h404, 8'h01, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC3},
    {11'h405, 8'hFF, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC3},
    {11'h401, 8'h02, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3},
    {11'h400, 8'h05, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  function automatic logic [15:0] pins();
    return {sync_sel, test1_out, master_en, e1_mode, test2_out, late_rev_mode, led};
  endfunction

  task automatic rd_status(string req, logic [7:0] exp);
    bus_addr = 11'h400; bus_rd = 1; #1;
    check(req, bus_rdata, exp);
    bus_rd = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 in reset
    check("R1", {pins(), irq_out}, 17'h0);
    rst_n = 1;
    @(negedge clk);
    tx_ser_in = 4'hA; line_rx_in = 4'h5; #1;
    check("R1", {line_tx_out, rx_ser_out}, {4'hA, 4'h5});
    rd_status("R1", 8'h00);

    // R2 R4 R7 R8 R11 table
    foreach (VEC[i]) begin
      wr(VEC[i][34:24], VEC[i][23:16]);
      check($sformatf("R2/R4/R7/R8/R11 vec%0d", i), pins(), VEC[i][15:0]);
    end

    // R3 R10 framer path
    wr(11'h401, 8'h05);
    rd_status("R3", 8'h01);
    check("R10", irq_out, 1'b0);
    framer_irq = 1; #1;
    check("R10", irq_out, 1'b1);
    rd_status("R3", 8'h05);
    wr(11'h401, 8'h01);
    #1 check("R10", irq_out, 1'b0);
    rd_status("R3", 8'h05);
    framer_irq = 0;

    // R9 pending flag
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    rd_status("R9", 8'h03);
    check("R10", irq_out, 1'b1);
    repeat (3) @(negedge clk);
    rd_status("R9", 8'h03);
    wr(11'h401, 8'h81);
    rd_status("R9", 8'h01);
    check("R10", irq_out, 1'b0);
    @(negedge clk);
    bus_addr = 11'h401; bus_wdata = 8'h81; bus_wr = 1; frame_tick = 1;
    @(negedge clk);
    bus_wr = 0; frame_tick = 0;
    rd_status("R9", 8'h03);
    wr(11'h401, 8'h81);
    rd_status("R9", 8'h01);
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    wr(11'h401, 8'h00);
    #1 check("R10", irq_out, 1'b0);
    rd_status("R9", 8'h02);

    // R11 reads
    bus_addr = 11'h401; bus_rd = 1; #1;
    check("R11", bus_rdata, 8'h00);
    bus_rd = 0; bus_addr = 11'h400; #1;
    check("R11", bus_rdata, 8'h00);

    // R5 R6 loopbacks
    wr(11'h401, 8'h20);
    tx_ser_in = 4'h3; line_rx_in = 4'hC; #1;
    check("R5", line_tx_out, 4'hC);
    check("R6", rx_ser_out, 4'hC);
    line_rx_in = 4'h9; #1;
    check("R5", line_tx_out, 4'h9);
    wr(11'h401, 8'h40);
    #1 check("R6", rx_ser_out, 4'h3);
    check("R5", line_tx_out, 4'h3);
    tx_ser_in = 4'h6; #1;
    check("R6", rx_ser_out, 4'h6);

    // R1 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1", {pins(), irq_out}, 17'h0);
    check("R1", rx_ser_out, 4'h9);
    rst_n = 1;
    finish_run();
  end
endmodule